// File: doc/BRIEF.md
# Command Queue Thread Control Register Block

This block holds the control and status registers for every hardware thread of a multi-thread command queue engine. Software reaches it through a small memory-mapped register bus with single-cycle writes and a one-cycle read latency. Each thread owns its own address window. In that window software can start a self-clearing warm reset, enable the thread, and request or release a suspension. It can also manage the thread's interrupt causes and masks, and set the current and end program counters and the priority.

On the engine side the block tells each thread's sequencer when it may run and when its prefetched commands must be discarded. The sequencer reports back instruction boundaries, completion, two error causes, event waits and whether it is busy. The block combines every thread's masked interrupt state into an active-low summary, one bit per thread, which software can read from a global register.

Program counters are kept in the engine's shifted address units. A parameter sets the shift to 0 or 3 bits, and one instruction step advances the counter by 8 bytes expressed in those units.

Top module: `cq_thread_ctl`

## Requirements
- R1: The global summary register is at byte address 0x10. Thread t's window starts at 0x100 + t*0x80 for t below N_THREADS. Inside a window the offsets are: 0x00 warm reset, 0x04 enable (bit 0), 0x08 suspend request (bit 0), 0x0C status, 0x10 interrupt status, 0x14 interrupt enable, 0x20 current address, 0x24 end address, 0x30 wait, 0x40 priority. A read of any other address returns 0.
- R2: Writing 1 to bit 0 at offset 0x00 starts a warm reset. That bit then reads 1 for RST_CYCLES cycles and afterwards reads 0. When the reset ends, the thread's enable, suspend request, suspend acknowledge, interrupt status, interrupt enable, current address, end address and priority are all zero. Other writes to the thread are ignored while the reset runs.
- R3: thr_run[t] is 1 exactly when the thread is enabled, not acknowledged as suspended, and not in warm reset.
- R4: After suspend bit 0 is written as 1, status bit 1 becomes 1 at the first seq_step of a busy, enabled thread. If the thread is disabled or seq_busy is 0, it becomes 1 one cycle after the write. A seq_step does not advance a suspended thread. Writing 0 clears status bit 1 in the same cycle, and thr_run returns.
- R5: Interrupt status bit 0 is set by seq_done, bit 1 by seq_err and bit 4 by seq_fault. A write clears every bit whose written value is 0 and keeps every bit whose written value is 1. An event that arrives in the same cycle as a clearing write leaves its bit set.
- R6: Interrupt enable keeps bits 0, 1 and 4. thr_irq_n[t] is 0 exactly when (status & enable) is nonzero. Bit t of the global register reads the same value as thr_irq_n[t].
- R7: A write to the current address stores the value and pulses thr_refetch[t] for one cycle after the write. A seq_step on a running thread adds 8 >> ADDR_SHIFT to the address. A software write in the same cycle as a step wins.
- R8: The end address reads back as written. Priority reads back as its low PRIO_W bits.
- R9: Bit 31 of the wait register reads seq_wait[t]. All its other bits read 0.
- R10: bus_rdata carries the addressed value in the cycle after bus_rd is high, and is 0 after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | BUS_AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| seq_busy | input | N_THREADS | Sequencer is executing, per thread |
| seq_step | input | N_THREADS | Instruction boundary pulse |
| seq_done | input | N_THREADS | Completion event |
| seq_err | input | N_THREADS | Error event, status bit 1 |
| seq_fault | input | N_THREADS | Error event, status bit 4 |
| seq_wait | input | N_THREADS | Thread blocked on an event token |
| thr_run | output | N_THREADS | Thread may execute |
| thr_refetch | output | N_THREADS | Discard prefetched commands |
| thr_irq_n | output | N_THREADS | Active-low interrupt summary |

## Verification
Two pairs of functions can meet in the same cycle. A software write of 0 to the interrupt status register can arrive together with a sequencer error pulse. A software write of the current address can arrive together with an instruction step. The bench provokes both by driving the bus strobe and the sequencer pulse in the same clock. It then reads back the register: the interrupt bit must still be set and the address must hold the written value, not the stepped one. A suspend request that waits for a step on a busy thread is also checked. The status must stay clear until the step and be set right after it, and a later step must not move the address.

// File: rtl/cqt_pkg.sv
package cqt_pkg;
    localparam int OFF_W = 7;

    localparam logic [OFF_W-1:0] OFF_WRST = 7'h00;
    localparam logic [OFF_W-1:0] OFF_EN   = 7'h04;
    localparam logic [OFF_W-1:0] OFF_SUSP = 7'h08;
    localparam logic [OFF_W-1:0] OFF_STAT = 7'h0C;
    localparam logic [OFF_W-1:0] OFF_ISTS = 7'h10;
    localparam logic [OFF_W-1:0] OFF_IEN  = 7'h14;
    localparam logic [OFF_W-1:0] OFF_PC   = 7'h20;
    localparam logic [OFF_W-1:0] OFF_END  = 7'h24;
    localparam logic [OFF_W-1:0] OFF_WAIT = 7'h30;
    localparam logic [OFF_W-1:0] OFF_PRIO = 7'h40;

    localparam int WIN_BASE = 'h100;
    localparam int WIN_SH   = 7;
    localparam int GLOB_IRQ = 'h10;

    localparam int IRQ_W     = 5;
    localparam int BIT_DONE  = 0;
    localparam int BIT_ERR   = 1;
    localparam int BIT_FAULT = 4;
    localparam logic [IRQ_W-1:0] IRQ_KEEP = 5'b10011;

    typedef struct packed {
        logic busy;
        logic step;
        logic done;
        logic err;
        logic fault;
        logic waiting;
    } seq_in_t;
endpackage

// File: rtl/cqt_decode.sv
module cqt_decode #(
    parameter int N_THREADS = 16,
    parameter int BUS_AW    = 12,
    parameter int IDX_W     = 4
) (
    input  logic [BUS_AW-1:0]        addr,
    output logic                     glob_hit,
    output logic                     thr_hit,
    output logic [IDX_W-1:0]         idx,
    output logic [cqt_pkg::OFF_W-1:0] off,
    output logic [N_THREADS-1:0]     sel
);
    import cqt_pkg::*;

    localparam int WW = BUS_AW - WIN_SH;
    localparam logic [WW-1:0] N_LIM = WW'(N_THREADS);

    logic [BUS_AW-1:0] rel;
    logic [WW-1:0]     widx;

    always_comb begin
        rel      = addr - BUS_AW'(WIN_BASE);
        widx     = rel[BUS_AW-1:WIN_SH];
        off      = rel[OFF_W-1:0];
        thr_hit  = (addr >= BUS_AW'(WIN_BASE)) && (widx < N_LIM);
        glob_hit = (addr == BUS_AW'(GLOB_IRQ));
        idx      = IDX_W'(widx);
    end

    for (genvar i = 0; i < N_THREADS; i++) begin : g_sel
        assign sel[i] = thr_hit && (widx == WW'(i));
    end
endmodule

// File: rtl/cqt_thread.sv
module cqt_thread #(
    parameter int PC_W       = 32,
    parameter int PRIO_W     = 3,
    parameter int RST_CYCLES = 4,
    parameter int STEP       = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [cqt_pkg::OFF_W-1:0] off,
    input  logic [31:0]               wdata,
    input  cqt_pkg::seq_in_t          seq,
    output logic [31:0]               rdata,
    output logic                      run,
    output logic                      refetch,
    output logic                      irq,
    output logic                      rst_busy
);
    import cqt_pkg::*;

    localparam int CNT_W = $clog2(RST_CYCLES) + 1;

    typedef struct packed {
        logic              en;
        logic              susp_req;
        logic              susp_ack;
        logic              rst_busy;
        logic [CNT_W-1:0]  rst_cnt;
        logic [IRQ_W-1:0]  irq_sts;
        logic [IRQ_W-1:0]  irq_en;
        logic [PC_W-1:0]   pc;
        logic [PC_W-1:0]   end_a;
        logic [PRIO_W-1:0] prio;
        logic              refetch;
    } th_state_t;

    th_state_t st_d, st_q;
    logic [IRQ_W-1:0] ev;

    always_comb begin
        st_d         = st_q;
        st_d.refetch = 1'b0;
        run          = st_q.en & ~st_q.susp_ack & ~st_q.rst_busy;

        ev            = '0;
        ev[BIT_DONE]  = seq.done;
        ev[BIT_ERR]   = seq.err;
        ev[BIT_FAULT] = seq.fault;

        if (run && seq.step) begin
            st_d.pc = st_q.pc + PC_W'(STEP);
        end

        if (wr_en && !st_q.rst_busy) begin
            case (off)
                OFF_WRST: if (wdata[0]) begin
                    st_d.rst_busy = 1'b1;
                    st_d.rst_cnt  = CNT_W'(RST_CYCLES - 1);
                end
                OFF_EN:   st_d.en       = wdata[0];
                OFF_SUSP: st_d.susp_req = wdata[0];
                OFF_ISTS: st_d.irq_sts  = st_q.irq_sts & wdata[IRQ_W-1:0];
                OFF_IEN:  st_d.irq_en   = wdata[IRQ_W-1:0] & IRQ_KEEP;
                OFF_PC: begin
                    st_d.pc      = wdata[PC_W-1:0];
                    st_d.refetch = 1'b1;
                end
                OFF_END:  st_d.end_a = wdata[PC_W-1:0];
                OFF_PRIO: st_d.prio  = wdata[PRIO_W-1:0];
                default: ;
            endcase
        end

        st_d.irq_sts = (st_d.irq_sts | ev) & IRQ_KEEP;

        if (!st_d.susp_req) begin
            st_d.susp_ack = 1'b0;
        end else if (st_q.susp_req && (!st_q.en || !seq.busy || seq.step)) begin
            st_d.susp_ack = 1'b1;
        end

        if (st_q.rst_busy) begin
            if (st_q.rst_cnt == '0) begin
                st_d = '0;
            end else begin
                st_d.rst_cnt = st_q.rst_cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (off)
            OFF_WRST: rdata[0]            = st_q.rst_busy;
            OFF_EN:   rdata[0]            = st_q.en;
            OFF_SUSP: rdata[0]            = st_q.susp_req;
            OFF_STAT: rdata[1]            = st_q.susp_ack;
            OFF_ISTS: rdata[IRQ_W-1:0]    = st_q.irq_sts;
            OFF_IEN:  rdata[IRQ_W-1:0]    = st_q.irq_en;
            OFF_PC:   rdata[PC_W-1:0]     = st_q.pc;
            OFF_END:  rdata[PC_W-1:0]     = st_q.end_a;
            OFF_WAIT: rdata[31]           = seq.waiting;
            OFF_PRIO: rdata[PRIO_W-1:0]   = st_q.prio;
            default: ;
        endcase
    end

    assign refetch  = st_q.refetch;
    assign irq      = |(st_q.irq_sts & st_q.irq_en);
    assign rst_busy = st_q.rst_busy;
endmodule

// File: rtl/cq_thread_ctl.sv
module cq_thread_ctl #(
    parameter int N_THREADS  = 16,
    parameter int ADDR_SHIFT = 0,
    parameter int BUS_AW     = 12,
    parameter int PC_W       = 32,
    parameter int PRIO_W     = 3,
    parameter int RST_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [N_THREADS-1:0] seq_busy,
    input  logic [N_THREADS-1:0] seq_step,
    input  logic [N_THREADS-1:0] seq_done,
    input  logic [N_THREADS-1:0] seq_err,
    input  logic [N_THREADS-1:0] seq_fault,
    input  logic [N_THREADS-1:0] seq_wait,
    output logic [N_THREADS-1:0] thr_run,
    output logic [N_THREADS-1:0] thr_refetch,
    output logic [N_THREADS-1:0] thr_irq_n
);
    import cqt_pkg::*;

    localparam int IDX_W     = (N_THREADS > 1) ? $clog2(N_THREADS) : 1;
    localparam int INST_STEP = 8 >> ADDR_SHIFT;

    logic                 glob_hit, thr_hit;
    logic [IDX_W-1:0]     dec_idx;
    logic [OFF_W-1:0]     dec_off;
    logic [N_THREADS-1:0] dec_sel;
    logic [N_THREADS-1:0] irq_vec;
    logic [N_THREADS-1:0] rst_busy_vec;
    logic [31:0]          thr_rdata [N_THREADS];
    logic [31:0]          rdata_d, rdata_q;

    cqt_decode #(
        .N_THREADS(N_THREADS),
        .BUS_AW   (BUS_AW),
        .IDX_W    (IDX_W)
    ) u_dec (
        .addr    (bus_addr),
        .glob_hit(glob_hit),
        .thr_hit (thr_hit),
        .idx     (dec_idx),
        .off     (dec_off),
        .sel     (dec_sel)
    );

    for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
        seq_in_t sq;
        assign sq = '{busy: seq_busy[t], step: seq_step[t], done: seq_done[t],
                      err: seq_err[t], fault: seq_fault[t], waiting: seq_wait[t]};

        cqt_thread #(
            .PC_W      (PC_W),
            .PRIO_W    (PRIO_W),
            .RST_CYCLES(RST_CYCLES),
            .STEP      (INST_STEP)
        ) u_thr (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_wr && dec_sel[t]),
            .off     (dec_off),
            .wdata   (bus_wdata),
            .seq     (sq),
            .rdata   (thr_rdata[t]),
            .run     (thr_run[t]),
            .refetch (thr_refetch[t]),
            .irq     (irq_vec[t]),
            .rst_busy(rst_busy_vec[t])
        );
    end

    assign thr_irq_n = ~irq_vec;

    always_comb begin
        rdata_d = '0;
        if (bus_rd) begin
            if (glob_hit) begin
                rdata_d[N_THREADS-1:0] = thr_irq_n;
            end else if (thr_hit) begin
                rdata_d = thr_rdata[dec_idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/cq_thread_ctl_chk.sv
module cq_thread_ctl_chk #(
    parameter int N_THREADS  = 16,
    parameter int BUS_AW     = 12,
    parameter int RST_CYCLES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic [BUS_AW-1:0]    bus_addr,
    input logic [31:0]          bus_rdata,
    input logic [N_THREADS-1:0] seq_busy,
    input logic [N_THREADS-1:0] seq_step,
    input logic [N_THREADS-1:0] thr_run,
    input logic [N_THREADS-1:0] thr_refetch,
    input logic [N_THREADS-1:0] thr_irq_n,
    input logic [N_THREADS-1:0] rst_busy_vec
);
    logic [7:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len <= '0;
        end else if (rst_busy_vec[0]) begin
            busy_len <= busy_len + 8'd1;
        end else begin
            busy_len <= '0;
        end
    end

    AST_RST_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len <= 8'(RST_CYCLES)); // R2

    AST_RUN_RISE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((thr_run & ~$past(thr_run)) != '0) |-> $past(bus_wr)); // R3

    AST_RUN_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((~thr_run & $past(thr_run)) != '0) |->
            ($past(bus_wr) || ($past(seq_step | ~seq_busy) != '0))); // R4

    AST_GLOBAL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && (bus_addr == BUS_AW'(16))) |->
            (bus_rdata[N_THREADS-1:0] == $past(thr_irq_n))); // R6

    AST_REFETCH_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_refetch != '0) |-> $past(bus_wr)); // R7

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> (bus_rdata == '0)); // R10
endmodule

bind cq_thread_ctl cq_thread_ctl_chk #(
    .N_THREADS (N_THREADS),
    .BUS_AW    (BUS_AW),
    .RST_CYCLES(RST_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .seq_busy    (seq_busy),
    .seq_step    (seq_step),
    .thr_run     (thr_run),
    .thr_refetch (thr_refetch),
    .thr_irq_n   (thr_irq_n),
    .rst_busy_vec(rst_busy_vec)
);

// File: tb/cq_thread_ctl_tb.sv
module cq_thread_ctl_tb;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] seq_busy = '1, seq_step = '0, seq_done = '0;
    logic [N-1:0] seq_err = '0, seq_fault = '0, seq_wait = '0;
    logic [N-1:0] thr_run, thr_refetch, thr_irq_n;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];
    logic rd_seen = 1'b0;

    always #5 clk = ~clk;

    cq_thread_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .seq_busy(seq_busy), .seq_step(seq_step), .seq_done(seq_done),
        .seq_err(seq_err), .seq_fault(seq_fault), .seq_wait(seq_wait),
        .thr_run(thr_run), .thr_refetch(thr_refetch), .thr_irq_n(thr_irq_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        exp_t it;
        @(negedge clk);
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                check("R10 unexpected read data", 32'h1, 32'h0);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        check("R3 run after reset", 32'(thr_run), 32'h0);
        check("R6 irq_n after reset", 32'(thr_irq_n), 32'hFFFF);
        rd(12'h010, 32'h0000FFFF, "R10 R6 global after reset");
        rd(12'h104, 32'h0, "R1 enable after reset");

        // R7: address write and refetch pulse
        wr(12'h120, 32'h1000);
        check("R7 refetch pulse", 32'(thr_refetch), 32'h1);
        idle(1);
        check("R7 refetch one cycle", 32'(thr_refetch), 32'h0);
        rd(12'h120, 32'h1000, "R7 address readback");

        wr(12'h104, 32'h1);
        check("R3 run when enabled", 32'(thr_run[0]), 32'h1);

        @(negedge clk); seq_step[0] = 1'b1;
        @(negedge clk); seq_step[0] = 1'b0;
        rd(12'h120, 32'h1008, "R7 step advances");

        // R7 collision: write and step in one cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h120; bus_wdata = 32'h2000; seq_step[0] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; seq_step[0] = 1'b0;
        rd(12'h120, 32'h2000, "R7 write wins over step");

        // R8: thread 3 window
        wr(12'h2A4, 32'h1040);
        wr(12'h2C0, 32'h5);
        rd(12'h2A4, 32'h1040, "R8 end address");
        rd(12'h2C0, 32'h5, "R8 priority");
        wr(12'h2C0, 32'hFF);
        rd(12'h2C0, 32'h7, "R8 priority width");

        // R4: busy thread waits for a step
        wr(12'h108, 32'h1);
        rd(12'h10C, 32'h0, "R4 no ack before step");
        check("R4 still running", 32'(thr_run[0]), 32'h1);
        @(negedge clk); seq_step[0] = 1'b1;
        @(negedge clk); seq_step[0] = 1'b0;
        rd(12'h10C, 32'h2, "R4 ack at step");
        check("R4 stopped", 32'(thr_run[0]), 32'h0);
        @(negedge clk); seq_step[0] = 1'b1;
        @(negedge clk); seq_step[0] = 1'b0;
        rd(12'h120, 32'h2008, "R4 no advance while suspended");
        wr(12'h108, 32'h0);
        check("R4 run after resume", 32'(thr_run[0]), 32'h1);
        rd(12'h10C, 32'h0, "R4 ack cleared");

        // R4: disabled thread 2 and idle thread 6
        wr(12'h208, 32'h1);
        idle(1);
        rd(12'h20C, 32'h2, "R4 disabled acks at once");
        wr(12'h404, 32'h1);
        seq_busy[6] = 1'b0;
        wr(12'h408, 32'h1);
        idle(1);
        rd(12'h40C, 32'h2, "R4 idle acks at once");
        check("R4 idle thread stopped", 32'(thr_run[6]), 32'h0);

        // R5 / R6 interrupts on thread 0
        wr(12'h114, 32'hFFFFFFFF);
        rd(12'h114, 32'h13, "R6 enable bits kept");
        @(negedge clk); seq_done[0] = 1'b1;
        @(negedge clk); seq_done[0] = 1'b0;
        check("R6 irq_n low", 32'(thr_irq_n), 32'hFFFE);
        rd(12'h010, 32'h0000FFFE, "R6 global bit");
        rd(12'h110, 32'h1, "R5 done bit");
        wr(12'h110, 32'hFFFFFFFF);
        rd(12'h110, 32'h1, "R5 write one keeps");
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h110; bus_wdata = 32'h0; seq_err[0] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; seq_err[0] = 1'b0;
        rd(12'h110, 32'h2, "R5 event wins over clear");
        check("R6 irq still low", 32'(thr_irq_n[0]), 32'h0);
        wr(12'h110, 32'h0);
        check("R6 irq released", 32'(thr_irq_n), 32'hFFFF);
        rd(12'h110, 32'h0, "R5 cleared");

        @(negedge clk); seq_fault[1] = 1'b1;
        @(negedge clk); seq_fault[1] = 1'b0;
        rd(12'h190, 32'h10, "R5 fault bit");
        check("R6 masked no irq", 32'(thr_irq_n), 32'hFFFF);

        // R9 wait
        seq_wait[5] = 1'b1;
        rd(12'h3B0, 32'h80000000, "R9 waiting");
        seq_wait[5] = 1'b0;
        rd(12'h3B0, 32'h0, "R9 not waiting");

        // R1 unmapped
        rd(12'h118, 32'h0, "R1 hole in window");
        rd(12'h004, 32'h0, "R1 global hole");
        rd(12'h900, 32'h0, "R1 beyond threads");

        // R2 warm reset of thread 0
        wr(12'h100, 32'h1);
        rd(12'h100, 32'h1, "R2 busy reads one");
        check("R2 run held off", 32'(thr_run[0]), 32'h0);
        idle(6);
        rd(12'h100, 32'h0, "R2 self clear");
        rd(12'h104, 32'h0, "R2 enable cleared");
        rd(12'h120, 32'h0, "R2 address cleared");
        rd(12'h114, 32'h0, "R2 irq enable cleared");
        check("R2 run after reset", 32'(thr_run[0]), 32'h0);

        idle(3);
        if (sb_q.size() != 0) check("R10 reads left", 32'(sb_q.size()), 32'h0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule